// File: doc/BRIEF.md
# Pattern-Mask Pixel Culling Filter

This block thins a raster pixel stream by a fixed repeating pattern. Three 8-bit masks control it. One mask covers lines and selects which lines of a frame survive. The other two cover pixels within a line: one is used on even lines and the other on odd lines. In every mask a 1 keeps the pixel or line and a 0 drops it. The line pattern and the pixel pattern apply together. A pixel reaches the output only when its line is kept and its position in that line is kept.

The input is a valid strobe with data. Line-start and frame-start markers ride on the first valid pixel of a line or frame. The output is the same stream delayed by one register stage. Its valid strobe is low for every dropped pixel. The mask inputs are captured on the frame-start pixel and stay fixed for the rest of that frame. Software may therefore rewrite them at any time without tearing a frame.

Top module: `pattern_cull`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_sol and out_sof are 0.
- R2: A kept pixel appears on out_valid/out_data exactly one clock after it is presented, with its data unchanged.
- R3: The pixel mask bit used for a pixel is the count of valid pixels since the last line start, modulo 8. The pixel that carries the line start uses bit 0, and the eighth pixel after it uses bit 0 again.
- R4: Line parity follows the count of input lines since frame start, whether or not those lines are kept. Line 0 counts as even and uses mask_h_even; odd lines use mask_h_odd.
- R5: The line mask bit used for a line is the count of line starts since frame start, modulo 8, with the frame-start line at bit 0. A line whose bit is 0 gives no out_valid and no out_sol.
- R6: The three masks are sampled on the valid pixel that carries in_sof, and that pixel already uses them. Changes to the mask inputs later in the frame have no effect until the next frame start.
- R7: Until the first frame start after reset, no pixel is kept and no out_sol is produced.
- R8: out_sof pulses one clock after every valid pixel that carries in_sof. out_sol pulses one clock after every valid line-start pixel (in_sol or in_sof) whose line is kept, even if that pixel itself is dropped by the pixel mask.
- R9: Cycles with in_valid low produce out_valid low, and they neither advance nor reset the pixel and line positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_data | input | DW | Input pixel value |
| in_sol | input | 1 | First pixel of a line (qualified by in_valid) |
| in_sof | input | 1 | First pixel of a frame, also starts line 0 (qualified by in_valid) |
| mask_h_even | input | 8 | Pixel keep mask for even lines, bit n for position n |
| mask_h_odd | input | 8 | Pixel keep mask for odd lines, bit n for position n |
| mask_v | input | 8 | Line keep mask, bit n for line position n |
| out_valid | output | 1 | Output pixel strobe, low for dropped pixels |
| out_data | output | DW | Output pixel value |
| out_sol | output | 1 | Line-start marker for kept lines |
| out_sof | output | 1 | Frame-start marker |

## Verification
Each output has one register stage. The valid strobe, data and both markers for a pixel presented before rising edge k are all due just after edge k. The bench drives each input on the falling edge. It then waits for the next rising edge, lets a nanosecond pass, and compares all four outputs against a model of the masks kept in the bench. No result is ever read later than that edge. Idle cycles are checked the same way, so an idle cycle can neither shift a pixel's expected edge nor its pattern position.

// File: rtl/pattern_cull.sv
module pattern_cull #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic [7:0]    mask_h_even,
  input  logic [7:0]    mask_h_odd,
  input  logic [7:0]    mask_v,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sol,
  output logic          out_sof
);
  localparam int MW = 8;
  localparam int IW = $clog2(MW);

  logic [MW-1:0] he_q, ho_q, v_q;
  logic [IW-1:0] ln_q, px_q;

  wire           lstart = in_valid & (in_sol | in_sof);
  wire [IW-1:0]  ln_n   = in_sof ? '0 : (in_sol ? ln_q + 1'b1 : ln_q);
  wire [IW-1:0]  px_n   = lstart ? '0 : px_q;
  wire [MW-1:0]  he_a   = in_sof ? mask_h_even : he_q;
  wire [MW-1:0]  ho_a   = in_sof ? mask_h_odd  : ho_q;
  wire [MW-1:0]  v_a    = in_sof ? mask_v      : v_q;
  wire [MW-1:0]  hsel   = ln_n[0] ? ho_a : he_a;
  wire           vkeep  = v_a[ln_n];
  wire           keep   = in_valid & vkeep & hsel[px_n];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      he_q      <= '0;
      ho_q      <= '0;
      v_q       <= '0;
      ln_q      <= '0;
      px_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      if (in_valid) begin
        ln_q <= ln_n;
        px_q <= px_n + 1'b1;
      end
      if (in_valid & in_sof) begin
        he_q <= mask_h_even;
        ho_q <= mask_h_odd;
        v_q  <= mask_v;
      end
      out_valid <= keep;
      if (keep) out_data <= in_data;
      out_sol <= lstart & vkeep;
      out_sof <= in_valid & in_sof;
    end
  end
endmodule

module pattern_cull_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          in_sol,
  input logic          in_sof,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_sol,
  input logic          out_sof
);
  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!out_valid || out_data == $past(in_data)));
  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  sof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> out_sof);
  // R8
  sof_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> $past(in_valid && in_sof));
  // R5
  sol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> $past(in_valid && (in_sol || in_sof)));
endmodule

bind pattern_cull pattern_cull_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_sol(in_sol), .in_sof(in_sof), .out_valid(out_valid),
  .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof)
);

// File: tb/pattern_cull_tb_top.sv
`timescale 1ns/1ps
module pattern_cull_tb_top;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_sol = 1'b0;
  logic          in_sof = 1'b0;
  logic [7:0]    mask_h_even = '0;
  logic [7:0]    mask_h_odd = '0;
  logic [7:0]    mask_v = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_sol;
  logic          out_sof;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_he = '0, m_ho = '0, m_v = '0;
  int ln = 0, px = 0;

  always #2.5 clk = ~clk;

  pattern_cull #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sol(in_sol), .in_sof(in_sof), .mask_h_even(mask_h_even),
    .mask_h_odd(mask_h_odd), .mask_v(mask_v), .out_valid(out_valid),
    .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pix(input logic [DW-1:0] d, input bit sol, input bit sof, input string req);
    logic [7:0] hm;
    bit vk, kp;
    if (sof) begin
      m_he = mask_h_even; m_ho = mask_h_odd; m_v = mask_v;
      ln = 0; px = 0;
    end else if (sol) begin
      ln++; px = 0;
    end
    hm = (ln % 2 == 1) ? m_ho : m_he;
    vk = m_v[ln % 8];
    kp = vk && hm[px % 8];
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sol = sol; in_sof = sof;
    @(posedge clk); #1;
    chk(req, "out_valid", int'(out_valid), int'(kp));
    if (kp) chk(req, "out_data", int'(out_data), int'(d));
    chk(req, "out_sol", int'(out_sol), int'((sol || sof) && vk));
    chk(req, "out_sof", int'(out_sof), int'(sof));
    px++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_data = '1;
      @(posedge clk); #1;
      chk("R9", "out_valid idle", int'(out_valid), 0);
      chk("R9", "out_sol idle", int'(out_sol), 0);
    end
  endtask

  task automatic frame(input int lines, input int npx, input string req);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < npx; p++)
        pix(DW'(l * 37 + p * 5 + 1), p == 0, (l == 0) && (p == 0), req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "out_sol in reset", int'(out_sol), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "out_sof after reset", int'(out_sof), 0);
  endtask

  task automatic t_before_sof();
    mask_h_even = 8'hFF; mask_h_odd = 8'hFF; mask_v = 8'hFF;
    for (int i = 0; i < 10; i++) pix(DW'(i + 3), i % 5 == 0, 1'b0, "R7");
  endtask

  task automatic t_hmask();
    mask_h_even = 8'hA5; mask_h_odd = 8'h3C; mask_v = 8'hFF;
    frame(4, 19, "R3_R4");
  endtask

  task automatic t_vmask();
    mask_h_even = 8'hFF; mask_h_odd = 8'hFE; mask_v = 8'h5A;
    frame(11, 4, "R5");
  endtask

  task automatic t_latch();
    mask_h_even = 8'h0F; mask_h_odd = 8'hF0; mask_v = 8'hB7;
    pix(DW'(100), 1'b1, 1'b1, "R6");
    mask_h_even = 8'h00; mask_h_odd = 8'h00; mask_v = 8'h00;
    for (int p = 1; p < 9; p++) pix(DW'(100 + p), 1'b0, 1'b0, "R6");
    for (int l = 1; l < 4; l++)
      for (int p = 0; p < 9; p++) pix(DW'(200 + p), p == 0, 1'b0, "R6");
    pix(DW'(300), 1'b1, 1'b1, "R6");
    pix(DW'(301), 1'b0, 1'b0, "R6");
  endtask

  task automatic t_gaps();
    mask_h_even = 8'h6D; mask_h_odd = 8'h92; mask_v = 8'hDF;
    for (int l = 0; l < 6; l++)
      for (int p = 0; p < 11; p++) begin
        pix(DW'(l * 11 + p), p == 0, (l == 0) && (p == 0), "R9");
        if ((p % 3) == 1) idle(2);
      end
    idle(1);
  endtask

  task automatic t_first_drop();
    mask_h_even = 8'hFE; mask_h_odd = 8'hFE; mask_v = 8'hFF;
    frame(2, 3, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_before_sof();
    t_hmask();
    t_vmask();
    t_latch();
    t_gaps();
    t_first_drop();
    idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule